// File: doc/BRIEF.md
# Interval Timer Bus Access Sequencer

This block is the bus-facing front end of a multi-channel interval timer. A host reaches it over an 8-bit data bus with a 2-bit address. Addresses 0 up to the channel count minus one are the channel data ports, and address 3 is the control register. The block decodes control words, which set a channel's access mode, counting mode and decimal flag. Control words also issue the count-latch command and the multi-channel read-back command. Each channel keeps its own byte sequencing for reads and for writes, a one-shot count snapshot and a one-shot status snapshot.

The counting engines are outside this block. Each engine receives a one-cycle load strobe and the 16-bit value to load, plus its mode and decimal flag. In return it presents its live count and its output level. Those are sampled here when a latch is taken, when a status is captured, or when an unlatched read is served.

Read data is combinational and valid during the cycle in which `bus_rd` is high. Every state change caused by that read takes effect on the clock edge that ends the cycle. A write takes effect on the clock edge where `bus_wr` is high. The host never asserts `bus_rd` and `bus_wr` in the same cycle.

Top module: `tmr_access_seq`

## Requirements
- R1: After reset every channel uses low-then-high access, counting mode 3 and decimal flag 0, with both byte toggles on the low byte. No load strobe and no latched count or status is pending, so reads return the live count.
- R2: A write to address 3 whose bits 7:6 name a channel (0, 1, 2) and whose bits 5:4 are non-zero sets that channel's access mode from bits 5:4 (01 low only, 10 high only, 11 low then high). It sets the counting mode from bits 3:1 and the decimal flag from bit 0, all visible on `mode_o`/`bcd_o` from the next cycle. It also returns both the read and the write toggle to the low byte.
- R3: A control word with bits 5:4 equal to 00 captures the addressed channel's live count at that clock edge. While that snapshot is unread, further latch commands leave it untouched.
- R4: A control word with bits 7:6 equal to 11 is a read-back command, in which bit 1, bit 2 and bit 3 select channels 0, 1 and 2. For each selected channel, bit 5 low takes a count snapshot under the rule of R3. Bit 4 low captures a status byte, but only if none is already pending. Unselected channels are unaffected.
- R5: The status byte carries the channel's output level in bit 7, zero in bit 6, the access mode in bits 5:4, the counting mode in bits 3:1 and the decimal flag in bit 0. The output level is taken at the clock edge of the command.
- R6: A data-port read returns a pending status byte first. If no status is pending it returns a pending count snapshot, and if neither is pending it returns the live count. Each read consumes exactly one byte.
- R7: A count snapshot taken in low-then-high mode is returned as the low byte and then the high byte, and then cleared. In low-only or high-only mode it returns the matching byte once and is cleared.
- R8: Unlatched reads in low-then-high mode alternate low and high bytes, using a read toggle that data writes do not move. In low-only and high-only modes they always return the same byte of the live count.
- R9: In low-then-high mode the first data byte is held and the channel is loaded with {second, first} when the second byte arrives. Low-only writes load {00, byte} and high-only writes load {byte, 00}. The strobe on `load_stb_o` is high for the one cycle after the write edge, with the value on `load_val_o`, and at most one channel is strobed at a time.
- R10: A read from address 3 returns 0xFF and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Port select: channel data ports, 3 = control |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, acts on the clock edge |
| bus_rd | input | 1 | Read strobe, one byte consumed per asserted edge |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| ch_count_i | input | NUM_CH*16 (48) | Live count of each counting engine |
| ch_out_i | input | NUM_CH (3) | Output level of each counting engine |
| load_stb_o | output | NUM_CH (3) | One-cycle load strobe per channel |
| load_val_o | output | 16 | Value to load into the strobed channel |
| mode_o | output | NUM_CH*3 (9) | Counting mode per channel |
| bcd_o | output | NUM_CH (1 each, 3) | Decimal counting flag per channel |

## Verification
The bench builds the block with its default of three channels, so all three read-back select bits address a real channel and address 3 is only the control port. With that setting a single read-back command can capture count and status for two channels at once. A later status-only command then hits a channel whose status is still pending and must be discarded. All three access modes are present together, so the bench can check that the read and write toggles stay apart while a pending latch sits behind a pending status.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_PAIR  = 2'b11
  } acc_e;

  // Snapshot state shares its encoding with the access mode that created it.
  typedef enum logic [1:0] {
    SNAP_NONE    = 2'b00,
    SNAP_LO_LAST = 2'b01,
    SNAP_HI_LAST = 2'b10,
    SNAP_LO_NEXT = 2'b11
  } snap_e;

  function automatic logic [BYTE_W-1:0] f_status(input logic out_lvl, input acc_e acc,
                                                 input logic [MODE_W-1:0] mode, input logic bcd);
    return {out_lvl, 1'b0, acc, mode, bcd};
  endfunction

  function automatic logic [BYTE_W-1:0] f_pick(input logic [CNT_W-1:0] val, input logic hi);
    return hi ? val[CNT_W-1:BYTE_W] : val[BYTE_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] f_single_load(input acc_e acc, input logic [BYTE_W-1:0] d);
    return (acc == ACC_HI) ? {d, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, d};
  endfunction
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NUM_CH-1:0] mode_wr,
  output logic [NUM_CH-1:0] latch_cnt,
  output logic [NUM_CH-1:0] latch_sts,
  output logic [NUM_CH-1:0] data_wr,
  output acc_e              ctl_acc,
  output logic [MODE_W-1:0] ctl_mode,
  output logic              ctl_bcd
);
  localparam logic [1:0] CTL_ADDR = 2'd3;
  localparam logic [1:0] RB_SEL   = 2'd3;

  logic       ctl_wr;
  logic       is_rb;
  logic [1:0] sel;

  assign ctl_wr   = wr_en && (addr == CTL_ADDR);
  assign sel      = wdata[7:6];
  assign is_rb    = (sel == RB_SEL);
  assign ctl_acc  = acc_e'(wdata[5:4]);
  assign ctl_mode = wdata[3:1];
  assign ctl_bcd  = wdata[0];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
    logic hit;
    assign hit          = ctl_wr && !is_rb && (sel == 2'(k));
    assign mode_wr[k]   = hit && (ctl_acc != ACC_LATCH);
    assign latch_cnt[k] = (hit && (ctl_acc == ACC_LATCH)) ||
                          (ctl_wr && is_rb && wdata[k+1] && !wdata[5]);
    assign latch_sts[k] = ctl_wr && is_rb && wdata[k+1] && !wdata[4];
    assign data_wr[k]   = wr_en && (addr == 2'(k));
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  acc_e              ctl_acc,
  input  logic [MODE_W-1:0] ctl_mode,
  input  logic              ctl_bcd,
  input  logic              latch_cnt,
  input  logic              latch_sts,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_pop,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              live_out,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic [MODE_W-1:0] mode,
  output logic              bcd
);
  acc_e              acc;
  logic              rd_hi;
  logic              wr_hi;
  logic [BYTE_W-1:0] wr_hold;
  snap_e             snap;
  logic [CNT_W-1:0]  snap_val;
  logic              sts_vld;
  logic [BYTE_W-1:0] sts_val;

  // Named events for the assertions
  logic pop_sts, pop_snap, pop_live;
  assign pop_sts  = rd_pop && sts_vld;
  assign pop_snap = rd_pop && !sts_vld && (snap != SNAP_NONE);
  assign pop_live = rd_pop && !sts_vld && (snap == SNAP_NONE);

  always_comb begin
    if (sts_vld)                rd_byte = sts_val;
    else if (snap != SNAP_NONE) rd_byte = f_pick(snap_val, snap == SNAP_HI_LAST);
    else if (acc == ACC_PAIR)   rd_byte = f_pick(live_cnt, rd_hi);
    else                        rd_byte = f_pick(live_cnt, acc == ACC_HI);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= ACC_PAIR;
      mode     <= MODE_W'(3);
      bcd      <= 1'b0;
      rd_hi    <= 1'b0;
      wr_hi    <= 1'b0;
      wr_hold  <= '0;
      snap     <= SNAP_NONE;
      snap_val <= '0;
      sts_vld  <= 1'b0;
      sts_val  <= '0;
      load_stb <= 1'b0;
      load_val <= '0;
    end else begin
      load_stb <= 1'b0;
      if (pop_sts)  sts_vld <= 1'b0;
      if (pop_snap) snap <= (snap == SNAP_LO_NEXT) ? SNAP_HI_LAST : SNAP_NONE;
      if (pop_live && acc == ACC_PAIR) rd_hi <= !rd_hi;
      if (latch_cnt && snap == SNAP_NONE) begin
        snap     <= snap_e'(acc);
        snap_val <= live_cnt;
      end
      if (latch_sts && !sts_vld) begin
        sts_vld <= 1'b1;
        sts_val <= f_status(live_out, acc, mode, bcd);
      end
      if (mode_wr) begin
        acc   <= ctl_acc;
        mode  <= ctl_mode;
        bcd   <= ctl_bcd;
        rd_hi <= 1'b0;
        wr_hi <= 1'b0;
      end
      if (data_wr) begin
        if (acc == ACC_PAIR) begin
          if (!wr_hi) begin
            wr_hold <= wdata;
            wr_hi   <= 1'b1;
          end else begin
            load_stb <= 1'b1;
            load_val <= {wdata, wr_hold};
            wr_hi    <= 1'b0;
          end
        end else begin
          load_stb <= 1'b1;
          load_val <= f_single_load(acc, wdata);
        end
      end
    end
  end

  // R2: a control word leaves both toggles on the low byte
  p_ctl_toggles_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (!rd_hi && !wr_hi));

  // R3: an unread snapshot keeps its value
  p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snap != SNAP_NONE && !rd_pop) |=> ($stable(snap_val) && $stable(snap)));

  // R4: a pending status is not replaced by a new capture
  p_sts_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_vld && latch_sts && !rd_pop) |=> $stable(sts_val));

  // R5: bit 6 of a captured status is always zero
  p_sts_bit6_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_vld |-> !sts_val[6]);

  // R6: reading the status leaves a pending snapshot in place
  p_sts_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_sts && !latch_cnt) |=> $stable(snap));

  // R9: the first byte of a pair never loads
  p_pair_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && acc == ACC_PAIR && !wr_hi) |=> !load_stb);
endmodule

// File: rtl/tmr_access_seq.sv
module tmr_access_seq
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              bus_addr,
  input  logic [7:0]              bus_wdata,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  output logic [7:0]              bus_rdata,
  input  logic [NUM_CH*16-1:0]    ch_count_i,
  input  logic [NUM_CH-1:0]       ch_out_i,
  output logic [NUM_CH-1:0]       load_stb_o,
  output logic [15:0]             load_val_o,
  output logic [NUM_CH*3-1:0]     mode_o,
  output logic [NUM_CH-1:0]       bcd_o
);
  localparam logic [BYTE_W-1:0] UNUSED_BYTE = '1;

  logic [NUM_CH-1:0] mode_wr, latch_cnt, latch_sts, data_wr, rd_pop;
  acc_e              ctl_acc;
  logic [MODE_W-1:0] ctl_mode;
  logic              ctl_bcd;
  logic [BYTE_W-1:0] ch_byte [NUM_CH];
  logic [CNT_W-1:0]  ch_load [NUM_CH];

  tmr_ctl_decode #(.NUM_CH(NUM_CH)) u_dec (
    .wr_en     (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .mode_wr   (mode_wr),
    .latch_cnt (latch_cnt),
    .latch_sts (latch_sts),
    .data_wr   (data_wr),
    .ctl_acc   (ctl_acc),
    .ctl_mode  (ctl_mode),
    .ctl_bcd   (ctl_bcd)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign rd_pop[k] = bus_rd && (bus_addr == 2'(k));

    tmr_chan_port u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wr   (mode_wr[k]),
      .ctl_acc   (ctl_acc),
      .ctl_mode  (ctl_mode),
      .ctl_bcd   (ctl_bcd),
      .latch_cnt (latch_cnt[k]),
      .latch_sts (latch_sts[k]),
      .data_wr   (data_wr[k]),
      .wdata     (bus_wdata),
      .rd_pop    (rd_pop[k]),
      .live_cnt  (ch_count_i[k*CNT_W +: CNT_W]),
      .live_out  (ch_out_i[k]),
      .rd_byte   (ch_byte[k]),
      .load_stb  (load_stb_o[k]),
      .load_val  (ch_load[k]),
      .mode      (mode_o[k*MODE_W +: MODE_W]),
      .bcd       (bcd_o[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      bus_rdata = UNUSED_BYTE;
      for (int k = 0; k < NUM_CH; k++)
        if (bus_addr == 2'(k)) bus_rdata = ch_byte[k];
    end
  end

  always_comb begin
    load_val_o = '0;
    for (int k = 0; k < NUM_CH; k++)
      if (load_stb_o[k]) load_val_o = load_val_o | ch_load[k];
  end

  // R9: one channel loads at a time
  p_one_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb_o));

  // R10: a read of the control address starts no load and touches no mode
  p_ctl_read_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 2'd3) |=> (load_stb_o == '0 && $stable(mode_o)));
endmodule

// File: tb/tmr_access_seq_bench.sv
module tmr_access_seq_bench;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [NCH*16-1:0] cnt_bus = '0;
  logic [NCH-1:0] out_bus = '0;
  logic [NCH-1:0] load_stb_o;
  logic [15:0] load_val_o;
  logic [NCH*3-1:0] mode_o;
  logic [NCH-1:0] bcd_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];
  string tag_q [$];

  always #5 clk = ~clk;

  tmr_access_seq #(.NUM_CH(NCH)) u_tmr_access_seq (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ch_count_i(cnt_bus), .ch_out_i(out_bus), .load_stb_o(load_stb_o),
    .load_val_o(load_val_o), .mode_o(mode_o), .bcd_o(bcd_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: samples read data before the edge that consumes the byte
  always @(negedge clk) begin
    #3;
    if (bus_rd) begin
      if (exp_q.size() == 0) check(32'(bus_rdata), 32'hDEAD, "unexpected read");
      else check(32'(bus_rdata), 32'(exp_q.pop_front()), tag_q.pop_front());
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [2:0] stb,
                    input logic [15:0] val, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    check(32'(load_stb_o), 32'(stb), tag);
    if (stb != 3'b000) check(32'(load_val_o), 32'(val), tag);
  endtask

  task automatic set_cnt(input int k, input logic [15:0] v);
    @(negedge clk);
    cnt_bus[k*16 +: 16] = v;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cnt_bus = {16'h0F0E, 16'hABCD, 16'h1234};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(32'(mode_o), 32'({3'd3, 3'd3, 3'd3}), "R1 mode after reset");
    check(32'(bcd_o), 0, "R1 bcd after reset");
    check(32'(load_stb_o), 0, "R1 no load after reset");
    rd(0, 8'h34, "R1 R8 live low");
    rd(0, 8'h12, "R8 live high");
    rd(0, 8'h34, "R8 live low again");
    // R9 pair write
    wr(0, 8'h78, 3'b000, 16'h0, "R9 first byte holds");
    wr(0, 8'h56, 3'b001, 16'h5678, "R9 pair load");
    // R2 control word, low-only channel 1
    wr(3, 8'h55, 3'b000, 16'h0, "R2 ctl ch1");
    check(32'(mode_o[5:3]), 2, "R2 mode ch1");
    check(32'(bcd_o[1]), 1, "R2 bcd ch1");
    wr(1, 8'h9A, 3'b010, 16'h009A, "R9 low-only load");
    rd(1, 8'hCD, "R8 low-only read");
    rd(1, 8'hCD, "R8 low-only read repeat");
    // high-only channel 2
    wr(3, 8'hA0, 3'b000, 16'h0, "R2 ctl ch2");
    check(32'(mode_o[8:6]), 0, "R2 mode ch2");
    wr(2, 8'h3C, 3'b100, 16'h3C00, "R9 high-only load");
    rd(2, 8'h0F, "R8 high-only read");
    rd(2, 8'h0F, "R8 high-only read repeat");
    // R8 read toggle independent of write toggle
    wr(3, 8'h38, 3'b000, 16'h0, "R2 ctl ch0 mode4");
    check(32'(mode_o[2:0]), 4, "R2 mode ch0");
    wr(0, 8'h11, 3'b000, 16'h0, "R9 hold 11");
    rd(0, 8'h34, "R8 read toggle untouched by write");
    wr(0, 8'h22, 3'b001, 16'h2211, "R9 load 2211");
    rd(0, 8'h12, "R8 read high");
    // R2 toggles reset by control word
    rd(0, 8'h34, "R8 read low");
    wr(3, 8'h38, 3'b000, 16'h0, "R2 ctl");
    rd(0, 8'h34, "R2 read toggle reset");
    wr(0, 8'h01, 3'b000, 16'h0, "R2 stray first byte");
    wr(3, 8'h38, 3'b000, 16'h0, "R2 ctl");
    wr(0, 8'h02, 3'b000, 16'h0, "R2 write toggle reset");
    wr(0, 8'h03, 3'b001, 16'h0302, "R2 pair after reset");
    // R3 / R7 latch in pair mode
    wr(3, 8'h00, 3'b000, 16'h0, "R3 latch ch0");
    set_cnt(0, 16'h4321);
    wr(3, 8'h00, 3'b000, 16'h0, "R3 second latch");
    rd(0, 8'h34, "R3 R7 latched low");
    rd(0, 8'h12, "R3 R7 latched high");
    rd(0, 8'h21, "R7 cleared live low");
    rd(0, 8'h43, "R7 cleared live high");
    // R7 single-byte latches
    wr(3, 8'h40, 3'b000, 16'h0, "R3 latch ch1");
    set_cnt(1, 16'h1111);
    rd(1, 8'hCD, "R7 latched low-only");
    rd(1, 8'h11, "R7 cleared after one");
    wr(3, 8'h80, 3'b000, 16'h0, "R3 latch ch2");
    set_cnt(2, 16'h2222);
    rd(2, 8'h0F, "R7 latched high-only");
    rd(2, 8'h22, "R7 cleared after one");
    // R4 R5 R6 read-back on ch0 and ch2
    set_cnt(0, 16'h5566);
    set_cnt(2, 16'h7788);
    out_bus = 3'b101;
    wr(3, 8'hCA, 3'b000, 16'h0, "R4 readback");
    set_cnt(0, 16'h0000);
    set_cnt(2, 16'h0000);
    out_bus = 3'b000;
    wr(3, 8'hE2, 3'b000, 16'h0, "R4 second status ignored");
    rd(0, 8'hB8, "R5 R6 status ch0 first");
    rd(0, 8'h66, "R6 latched low");
    rd(0, 8'h55, "R6 latched high");
    rd(2, 8'hA0, "R5 status ch2");
    rd(2, 8'h77, "R6 latched high-only");
    rd(2, 8'h00, "R6 live high");
    rd(1, 8'h11, "R4 unselected ch1 live");
    // R4 count-only read-back
    set_cnt(1, 16'h3344);
    wr(3, 8'hD4, 3'b000, 16'h0, "R4 count only ch1");
    set_cnt(1, 16'h9999);
    rd(1, 8'h44, "R4 count latched no status");
    rd(1, 8'h99, "R4 live after");
    // R4 status-only
    wr(3, 8'hE2, 3'b000, 16'h0, "R4 status only ch0");
    rd(0, 8'h38, "R5 status out low");
    rd(0, 8'h00, "R4 no count latched");
    set_cnt(0, 16'hABCD);
    rd(0, 8'hAB, "R8 live high");
    out_bus = 3'b010;
    wr(3, 8'hE4, 3'b000, 16'h0, "R4 status ch1");
    out_bus = 3'b000;
    rd(1, 8'h95, "R5 status bcd and mode");
    // R10 control address read
    wr(3, 8'h00, 3'b000, 16'h0, "R3 latch ch0");
    set_cnt(0, 16'h0000);
    rd(3, 8'hFF, "R10 unused read");
    rd(3, 8'hFF, "R10 unused read again");
    check(32'(load_stb_o), 0, "R10 no load");
    rd(0, 8'hCD, "R10 latch untouched");
    rd(0, 8'hAB, "R10 latch high");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check(32'(exp_q.size()), 0, "pending reads");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule